// File: doc/BRIEF.md
# Accumulator 16-bit Processor Core

This block is a small multi-cycle 16-bit processor core. It holds sixteen 16-bit general registers, of which register 0 doubles as the accumulator (AC), and a 16-bit program counter. It runs every instruction in two phases. The fetch phase reads the instruction word at the program counter. The execute phase carries out the operation and may read or write one more memory word. Memory is word-addressed and sits on a single address bus with separate read-data and write-data buses and a write strobe. Read data must be valid in the same cycle as the address, so the memory is read combinationally.

The top nibble of an instruction selects a register operation: moves, indirect access, push and pop, accumulator ALU operations, or in-place increment, decrement and invert. The low-order nibble of that upper byte (bits 11:8) names the register Rn. When the top nibble is zero, the same bits 11:8 instead select a non-register operation. These are the conditional short branches on the sign of AC, long jumps, call and return through an internal return stack, 8-bit immediate add and subtract, and character output and input. Character output is a one-cycle strobe. Character input stalls the core until a character is offered.

Top module: `acc16_core`

## Requirements
- R1: While rst_n is low and after it rises, the program counter and all sixteen registers are 0. During reset mem_we, out_valid and in_ready are low and mem_addr is 0.
- R2: The opcode is bits 15:12 and the register index n is bits 11:8. SET (0x1n00) loads Rn with the word after the instruction, and execution resumes at the word after that.
- R3: 0x2n00 copies Rn into AC (R0). 0x3n00 copies AC into Rn.
- R4: 0x4n00 loads AC from memory at the address held in Rn. 0x5n00 writes AC to memory at the address held in Rn.
- R5: PUSH (0x7n00) writes AC at the address in Rn, then Rn increases by 1. POP (0x6n00) loads AC from the address in Rn, then Rn decreases by 1. When n is 0, the pointer update wins over the loaded value.
- R6: 0x8n00, 0x9n00, 0xAn00, 0xBn00 and 0xFn00 replace AC with AC AND Rn, AC OR Rn, AC+Rn, AC-Rn and AC XOR Rn, modulo 2^16.
- R7: 0xCn00 inverts every bit of Rn. 0xDn00 decrements Rn. 0xEn00 increments Rn. Each result is written back to Rn.
- R8: Short branches 0x00tt to 0x06tt branch always, or when signed AC is >0, <0, >=0, <=0, !=0 or ==0, in that order of sub-code. A taken branch replaces the low byte of the incremented program counter with tt.
- R9: JMP (0x0700) and CALL (0x0800) continue at the 16-bit word that follows. CALL also pushes the address after that word onto an 8-entry return stack, and RET (0x0900) pops it into the program counter. Calls nest, and the stack pointer wraps.
- R10: ADI (0x0Aii) adds and SBI (0x0Bii) subtracts the zero-extended byte ii to or from AC. ADI with ii of 0, and the code 0x0F00, leave AC unchanged.
- R11: OUT (0x0C00) raises out_valid for exactly one cycle, with the low byte of AC on out_data, in the cycle after its execute phase.
- R12: IN (0x0D00) holds in_ready high and the program counter still while in_valid is low. On the first cycle with in_valid high, it loads AC with in_data zero-extended to 16 bits.
- R13: JP@ (0x0E00) continues at the address held in R0.
- R14: Every instruction takes one fetch cycle (mem_addr = PC) and one execute cycle, and IN may add stall cycles. mem_we is never high in a fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Word address for fetch, operand or data access |
| mem_rdata | input | 16 | Read data for mem_addr, same cycle |
| mem_wdata | output | 16 | Data to write (always AC) |
| mem_we | output | 1 | Write strobe for mem_addr |
| out_valid | output | 1 | One-cycle strobe for an output character |
| out_data | output | 8 | Output character |
| in_valid | input | 1 | An input character is offered |
| in_data | input | 8 | Input character |
| in_ready | output | 1 | The core is waiting on IN and will take in_data when in_valid is high |

## Verification
The assertions watch the control rhythm on every cycle. A fetch is always followed by an execute phase, with the program counter one higher. Memory writes occur only in execute. An output strobe never lasts two cycles. A stalled IN keeps in_ready high and the program counter frozen. Data results cannot be seen that way: ALU arithmetic, branch conditions on the sign of AC, push and pop pointer movement, nested call and return, and immediate zero-extension are shown only by the bench's programs. Those programs leave their results in memory or on the output port, where the bench compares them with its own reference functions.

// File: rtl/acc16_pkg.sv
package acc16_pkg;

    localparam int WORD_W = 16;
    localparam int CHAR_W = 8;
    localparam int NIB_W  = 4;

    typedef enum logic {
        ST_FETCH = 1'b0,
        ST_EXEC  = 1'b1
    } phase_e;

    // top-nibble opcodes
    localparam logic [NIB_W-1:0] OP_SYS  = 4'h0;
    localparam logic [NIB_W-1:0] OP_SET  = 4'h1;
    localparam logic [NIB_W-1:0] OP_GET  = 4'h2;
    localparam logic [NIB_W-1:0] OP_PUT  = 4'h3;
    localparam logic [NIB_W-1:0] OP_LDI  = 4'h4;
    localparam logic [NIB_W-1:0] OP_STI  = 4'h5;
    localparam logic [NIB_W-1:0] OP_POP  = 4'h6;
    localparam logic [NIB_W-1:0] OP_PUSH = 4'h7;
    localparam logic [NIB_W-1:0] OP_AND  = 4'h8;
    localparam logic [NIB_W-1:0] OP_OR   = 4'h9;
    localparam logic [NIB_W-1:0] OP_ADD  = 4'hA;
    localparam logic [NIB_W-1:0] OP_SUB  = 4'hB;
    localparam logic [NIB_W-1:0] OP_NOT  = 4'hC;
    localparam logic [NIB_W-1:0] OP_DEC  = 4'hD;
    localparam logic [NIB_W-1:0] OP_INC  = 4'hE;
    localparam logic [NIB_W-1:0] OP_XOR  = 4'hF;

    // non-register sub-codes (bits 11:8 when top nibble is zero)
    localparam logic [NIB_W-1:0] SY_JMP  = 4'h7;
    localparam logic [NIB_W-1:0] SY_CALL = 4'h8;
    localparam logic [NIB_W-1:0] SY_RET  = 4'h9;
    localparam logic [NIB_W-1:0] SY_ADDI = 4'hA;
    localparam logic [NIB_W-1:0] SY_SUBI = 4'hB;
    localparam logic [NIB_W-1:0] SY_OUT  = 4'hC;
    localparam logic [NIB_W-1:0] SY_IN   = 4'hD;
    localparam logic [NIB_W-1:0] SY_JPR  = 4'hE;
    localparam logic [NIB_W-1:0] SY_IDLE = 4'hF;

    typedef struct packed {
        phase_e              phase;
        logic [WORD_W-1:0]   pc;
        logic [WORD_W-1:0]   ir;
        logic                out_valid;
        logic [CHAR_W-1:0]   out_data;
    } core_state_t;

    // branch condition for sub-codes 0..6 on a signed accumulator
    function automatic logic branch_taken(input logic [NIB_W-1:0] sub,
                                          input logic [WORD_W-1:0] acc);
        logic neg;
        logic zero;
        neg  = acc[WORD_W-1];
        zero = (acc == '0);
        case (sub)
            4'h0:    return 1'b1;
            4'h1:    return !neg && !zero;
            4'h2:    return neg;
            4'h3:    return !neg;
            4'h4:    return neg || zero;
            4'h5:    return !zero;
            4'h6:    return zero;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/acc16_regs.sv
module acc16_regs
    import acc16_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NREG)-1:0]  rd_idx,
    output logic [WORD_W-1:0]        rd_val,
    output logic [WORD_W-1:0]        acc_val,
    input  logic                     wa_en,
    input  logic [$clog2(NREG)-1:0]  wa_idx,
    input  logic [WORD_W-1:0]        wa_data,
    input  logic                     wb_en,
    input  logic [$clog2(NREG)-1:0]  wb_idx,
    input  logic [WORD_W-1:0]        wb_data
);
    localparam int IDX_W = $clog2(NREG);

    logic [WORD_W-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [WORD_W-1:0] reg_d;
        always_comb begin
            reg_d = regs_q[g];
            if (wa_en && wa_idx == IDX_W'(g)) reg_d = wa_data;
            // port B (register side-effect) has priority
            if (wb_en && wb_idx == IDX_W'(g)) reg_d = wb_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= '0;
            else        regs_q[g] <= reg_d;
        end
    end

    assign rd_val  = regs_q[rd_idx];
    assign acc_val = regs_q[0];

endmodule

// File: rtl/acc16_alu.sv
module acc16_alu
    import acc16_pkg::*;
(
    input  logic [NIB_W-1:0]  op,
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] rv,
    output logic [WORD_W-1:0] acc_res,
    output logic [WORD_W-1:0] self_res
);
    always_comb begin
        case (op)
            OP_AND:  acc_res = acc & rv;
            OP_OR:   acc_res = acc | rv;
            OP_ADD:  acc_res = acc + rv;
            OP_SUB:  acc_res = acc - rv;
            OP_XOR:  acc_res = acc ^ rv;
            default: acc_res = acc;
        endcase
    end

    always_comb begin
        case (op)
            OP_NOT:  self_res = ~rv;
            OP_DEC:  self_res = rv - WORD_W'(1);
            OP_INC:  self_res = rv + WORD_W'(1);
            default: self_res = rv;
        endcase
    end

endmodule

// File: rtl/acc16_rstack.sv
module acc16_rstack
    import acc16_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [WORD_W-1:0] push_data,
    output logic [WORD_W-1:0] top
);
    localparam int PW = $clog2(DEPTH);

    logic [WORD_W-1:0] slot_q [DEPTH];
    logic [PW-1:0]     ptr_q, ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        if (push)     ptr_d = ptr_q + PW'(1);
        else if (pop) ptr_d = ptr_q - PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          slot_q[g] <= '0;
            else if (push && ptr_q == PW'(g))    slot_q[g] <= push_data;
        end
    end

    assign top = slot_q[ptr_q - PW'(1)];

endmodule

// File: rtl/acc16_core.sv
module acc16_core
    import acc16_pkg::*;
#(
    parameter int NREG     = 16,
    parameter int RS_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [15:0]       mem_addr,
    input  logic [15:0]       mem_rdata,
    output logic [15:0]       mem_wdata,
    output logic              mem_we,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready
);
    localparam int IDX_W  = $clog2(NREG);
    localparam int IMM_W  = WORD_W / 2;

    core_state_t c_q, c_d;

    logic [NIB_W-1:0]  op;
    logic [NIB_W-1:0]  sub;
    logic [IDX_W-1:0]  rn;
    logic [IMM_W-1:0]  imm;
    logic [WORD_W-1:0] imm_x;

    logic [WORD_W-1:0] acc, rv, acc_res, self_res, rs_top;
    logic              wa_en, wb_en, rs_push, rs_pop;
    logic [WORD_W-1:0] wa_data, wb_data;
    logic              is_exec;

    assign op    = c_q.ir[WORD_W-1 -: NIB_W];
    assign sub   = c_q.ir[WORD_W-NIB_W-1 -: NIB_W];
    assign rn    = c_q.ir[WORD_W-NIB_W-1 -: IDX_W];
    assign imm   = c_q.ir[IMM_W-1:0];
    assign imm_x = {{(WORD_W-IMM_W){1'b0}}, imm};

    acc16_regs #(.NREG(NREG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rn),
        .rd_val  (rv),
        .acc_val (acc),
        .wa_en   (wa_en),
        .wa_idx  ('0),
        .wa_data (wa_data),
        .wb_en   (wb_en),
        .wb_idx  (rn),
        .wb_data (wb_data)
    );

    acc16_alu u_alu (
        .op       (op),
        .acc      (acc),
        .rv       (rv),
        .acc_res  (acc_res),
        .self_res (self_res)
    );

    acc16_rstack #(.DEPTH(RS_DEPTH)) u_rstack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rs_push),
        .pop       (rs_pop),
        .push_data (c_q.pc + WORD_W'(1)),
        .top       (rs_top)
    );

    always_comb begin
        c_d           = c_q;
        c_d.out_valid = 1'b0;
        mem_addr      = c_q.pc;
        mem_we        = 1'b0;
        mem_wdata     = acc;
        wa_en         = 1'b0;
        wa_data       = acc;
        wb_en         = 1'b0;
        wb_data       = rv;
        rs_push       = 1'b0;
        rs_pop        = 1'b0;
        in_ready      = 1'b0;

        if (c_q.phase == ST_FETCH) begin
            c_d.ir    = mem_rdata;
            c_d.pc    = c_q.pc + WORD_W'(1);
            c_d.phase = ST_EXEC;
        end else begin
            c_d.phase = ST_FETCH;
            case (op)
                OP_SET: begin
                    wb_en   = 1'b1;
                    wb_data = mem_rdata;
                    c_d.pc  = c_q.pc + WORD_W'(1);
                end
                OP_GET: begin
                    wa_en   = 1'b1;
                    wa_data = rv;
                end
                OP_PUT: begin
                    wb_en   = 1'b1;
                    wb_data = acc;
                end
                OP_LDI: begin
                    mem_addr = rv;
                    wa_en    = 1'b1;
                    wa_data  = mem_rdata;
                end
                OP_STI: begin
                    mem_addr = rv;
                    mem_we   = 1'b1;
                end
                OP_POP: begin
                    mem_addr = rv;
                    wa_en    = 1'b1;
                    wa_data  = mem_rdata;
                    wb_en    = 1'b1;
                    wb_data  = rv - WORD_W'(1);
                end
                OP_PUSH: begin
                    mem_addr = rv;
                    mem_we   = 1'b1;
                    wb_en    = 1'b1;
                    wb_data  = rv + WORD_W'(1);
                end
                OP_AND, OP_OR, OP_ADD, OP_SUB, OP_XOR: begin
                    wa_en   = 1'b1;
                    wa_data = acc_res;
                end
                OP_NOT, OP_DEC, OP_INC: begin
                    wb_en   = 1'b1;
                    wb_data = self_res;
                end
                default: begin // OP_SYS
                    case (sub)
                        SY_JMP: begin
                            c_d.pc = mem_rdata;
                        end
                        SY_CALL: begin
                            rs_push = 1'b1;
                            c_d.pc  = mem_rdata;
                        end
                        SY_RET: begin
                            rs_pop = 1'b1;
                            c_d.pc = rs_top;
                        end
                        SY_ADDI: begin
                            wa_en   = 1'b1;
                            wa_data = acc + imm_x;
                        end
                        SY_SUBI: begin
                            wa_en   = 1'b1;
                            wa_data = acc - imm_x;
                        end
                        SY_OUT: begin
                            c_d.out_valid = 1'b1;
                            c_d.out_data  = acc[CHAR_W-1:0];
                        end
                        SY_IN: begin
                            in_ready = 1'b1;
                            if (in_valid) begin
                                wa_en   = 1'b1;
                                wa_data = {{(WORD_W-CHAR_W){1'b0}}, in_data};
                            end else begin
                                c_d.phase = ST_EXEC;
                            end
                        end
                        SY_JPR: begin
                            c_d.pc = acc;
                        end
                        SY_IDLE: begin
                        end
                        default: begin // short branches 0..6
                            if (branch_taken(sub, acc))
                                c_d.pc = {c_q.pc[WORD_W-1:IMM_W], imm};
                        end
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign out_valid = c_q.out_valid;
    assign out_data  = c_q.out_data;
    assign is_exec   = (c_q.phase == ST_EXEC);

endmodule

// File: rtl/acc16_core_chk.sv
module acc16_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_exec,
    input logic [15:0] pc_q,
    input logic        mem_we,
    input logic        out_valid,
    input logic        in_ready,
    input logic        in_valid
);
    AST_FETCH_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        !in_exec |=> in_exec && pc_q == $past(pc_q) + 16'd1); // R14

    AST_NO_WRITE_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> in_exec); // R14

    AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R11

    AST_IN_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready && !in_valid |=> in_ready && $stable(pc_q)); // R12

    AST_IN_READY_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> in_exec); // R12

endmodule

bind acc16_core acc16_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_exec   (is_exec),
    .pc_q      (c_q.pc),
    .mem_we    (mem_we),
    .out_valid (out_valid),
    .in_ready  (in_ready),
    .in_valid  (in_valid)
);

// File: tb/acc16_core_test.sv
module acc16_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_rdata, mem_wdata;
    logic        mem_we, out_valid, in_ready;
    logic [7:0]  out_data;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;

    always #10 clk = ~clk; // 50 MHz

    acc16_core uut (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we),
        .out_valid(out_valid), .out_data(out_data),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready)
    );

    logic [15:0] mem [0:1023];
    assign mem_rdata = mem[mem_addr[9:0]];
    always @(negedge clk) if (rst_n && mem_we) mem[mem_addr[9:0]] <= mem_wdata;

    int          n_checks = 0;
    int          n_errs   = 0;
    int          out_cnt  = 0;
    logic [7:0]  out_log [0:15];
    int          pp;
    int          cycles = 0;

    always @(negedge clk) if (rst_n && out_valid) begin
        if (out_cnt < 16) out_log[out_cnt] = out_data;
        out_cnt++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_errs++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic new_prog();
        rst_n = 1'b0;
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
        pp = 0;
        out_cnt = 0;
    endtask

    task automatic emit(input logic [15:0] w);
        mem[pp] = w;
        pp++;
    endtask

    task automatic halt();
        emit({8'h00, 8'(pp)});
    endtask

    task automatic start_run(input int n);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] alu_ref(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
        case (op)
            4'h8: return a & b;
            4'h9: return a | b;
            4'hA: return a + b;
            4'hB: return a - b;
            default: return a ^ b;
        endcase
    endfunction

    function automatic logic [15:0] self_ref(input logic [3:0] op, input logic [15:0] a);
        case (op)
            4'hC: return ~a;
            4'hD: return a - 16'd1;
            default: return a + 16'd1;
        endcase
    endfunction

    function automatic logic cond_ref(input int c, input logic [15:0] v);
        int s;
        s = int'($signed(v));
        case (c)
            0: return 1'b1;
            1: return s > 0;
            2: return s < 0;
            3: return s >= 0;
            4: return s <= 0;
            5: return s != 0;
            default: return s == 0;
        endcase
    endfunction

    localparam logic [15:0] DST = 16'h0300;

    initial begin
        int seed_init;
        logic [3:0] ops [5];
        logic [15:0] bv [4];
        seed_init = $urandom(32'h5EED);
        ops = '{4'h8, 4'h9, 4'hA, 4'hB, 4'hF};
        bv  = '{16'hFFFB, 16'h0000, 16'h0007, 16'h8000};

        // R1 reset state, R2/R14 fetch timing
        new_prog();
        emit(16'h1100); emit(16'h1234); halt();
        @(negedge clk);
        chk("R1 mem_addr in reset", mem_addr, 16'h0000);
        chk("R1 we/out/in_ready in reset", {13'd0, mem_we, out_valid, in_ready}, 16'h0000);
        rst_n = 1'b1;
        chk("R14 first fetch addr", mem_addr, 16'h0000);
        @(negedge clk);
        chk("R2 SET operand addr", mem_addr, 16'h0001);
        @(negedge clk);
        chk("R2 R14 next fetch skips operand", mem_addr, 16'h0002);

        // R1: registers read as zero after reset
        new_prog();
        emit(16'h1300); emit(DST); emit(16'h2500); emit(16'h5300); halt();
        start_run(40);
        chk("R1 register zero after reset", mem[DST], 16'h0000);

        // R6 random accumulator ALU ops
        for (int k = 0; k < 24; k++) begin
            logic [15:0] a, b;
            logic [3:0]  op;
            a  = 16'($urandom);
            b  = 16'($urandom);
            op = ops[$urandom % 5];
            new_prog();
            emit(16'h1100); emit(a); emit(16'h1200); emit(b);
            emit(16'h1300); emit(DST); emit(16'h2100);
            emit({op, 4'h2, 8'h00}); emit(16'h5300); halt();
            start_run(40);
            chk($sformatf("R6 op %h", op), mem[DST], alu_ref(op, a, b));
        end

        // R7 random in-place ops
        for (int k = 0; k < 12; k++) begin
            logic [15:0] a;
            logic [3:0]  op;
            a  = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h0000 : 16'($urandom);
            op = 4'hC + 4'($urandom % 3);
            if (k < 2) op = (k == 0) ? 4'hE : 4'hD;
            new_prog();
            emit(16'h1400); emit(a); emit(16'h1300); emit(DST);
            emit({op, 4'h4, 8'h00}); emit(16'h2400); emit(16'h5300); halt();
            start_run(40);
            chk($sformatf("R7 op %h", op), mem[DST], self_ref(op, a));
        end

        // R10 random immediates, zero-extension
        for (int k = 0; k < 12; k++) begin
            logic [15:0] a;
            logic [7:0]  im;
            logic        is_sub;
            a = 16'($urandom);
            im = (k == 0) ? 8'hFF : 8'($urandom);
            is_sub = k[0];
            new_prog();
            emit(16'h1300); emit(DST); emit(16'h1000); emit(a);
            emit({is_sub ? 8'h0B : 8'h0A, im}); emit(16'h5300); halt();
            start_run(40);
            chk("R10 ADI/SBI", mem[DST], is_sub ? a - {8'h00, im} : a + {8'h00, im});
        end

        // R10 no-operation codes
        new_prog();
        emit(16'h1300); emit(DST); emit(16'h1000); emit(16'h3C3C);
        emit(16'h0F00); emit(16'h0A00); emit(16'h5300); halt();
        start_run(40);
        chk("R10 nop codes keep AC", mem[DST], 16'h3C3C);

        // R8 branches over all conditions and sign cases
        for (int c = 0; c < 7; c++) begin
            for (int j = 0; j < 4; j++) begin
                int t;
                new_prog();
                emit(16'h1300); emit(DST); emit(16'h1100); emit(bv[j]); emit(16'h2100);
                t = pp + 5;
                emit({4'h0, 4'(c), 8'(t)});
                emit(16'h1000); emit(16'hF0F0); emit(16'h5300); halt();
                emit(16'h1000); emit(16'h7777); emit(16'h5300); halt();
                start_run(40);
                chk($sformatf("R8 cond %0d ac %h", c, bv[j]), mem[DST],
                    cond_ref(c, bv[j]) ? 16'h7777 : 16'hF0F0);
            end
        end

        // R3 register moves
        new_prog();
        emit(16'h1300); emit(DST); emit(16'h1900); emit(16'hABCD);
        emit(16'h2900); emit(16'h3A00); emit(16'h1000); emit(16'h0000);
        emit(16'h2A00); emit(16'h5300); halt();
        start_run(60);
        chk("R3 move through AC", mem[DST], 16'hABCD);

        // R4 indirect load and store
        new_prog();
        mem[16'h0210] = 16'h4242;
        emit(16'h1300); emit(DST); emit(16'h1B00); emit(16'h0210);
        emit(16'h4B00); emit(16'h5300); halt();
        start_run(40);
        chk("R4 indirect load/store", mem[DST], 16'h4242);

        // R5 push and pop
        new_prog();
        mem[16'h0202] = 16'hBEEF;
        emit(16'h1700); emit(16'h0200); emit(16'h1800); emit(DST);
        emit(16'h1000); emit(16'h1234); emit(16'h7700);
        emit(16'h1000); emit(16'h5678); emit(16'h7700);
        emit(16'h2700); emit(16'h5800); emit(16'hE800);
        emit(16'h6700); emit(16'h5800); emit(16'hE800);
        emit(16'h2700); emit(16'h5800); halt();
        start_run(80);
        chk("R5 push first", mem[16'h0200], 16'h1234);
        chk("R5 push second", mem[16'h0201], 16'h5678);
        chk("R5 pointer after pushes", mem[DST], 16'h0202);
        chk("R5 pop value", mem[DST + 1], 16'hBEEF);
        chk("R5 pointer after pop", mem[DST + 2], 16'h0201);

        // R9 nested call/return, JMP
        new_prog();
        emit(16'h1300); emit(DST); emit(16'h1000); emit(16'h0010);
        emit(16'h0800); emit(16'h0020);          // CALL 0x20
        emit(16'h0A02); emit(16'h0700); emit(16'h0040); // ADI 2, JMP 0x40
        emit(16'h1000); emit(16'hDEAD);
        pp = 16'h0020;
        emit(16'h0A40); emit(16'h0800); emit(16'h0030); emit(16'h0900);
        pp = 16'h0030;
        emit(16'h0A80); emit(16'h0900);
        pp = 16'h0040;
        emit(16'h5300); halt();
        start_run(80);
        chk("R9 nested call/return and jump", mem[DST], 16'h00D2);

        // R13 jump through R0
        new_prog();
        emit(16'h1300); emit(DST); emit(16'h1000); emit(16'h0050);
        emit(16'h0E00); emit(16'h1000); emit(16'hDEAD);
        pp = 16'h0050;
        emit(16'h0A05); emit(16'h5300); halt();
        start_run(40);
        chk("R13 JP@ target", mem[DST], 16'h0055);

        // R11 output strobe
        new_prog();
        emit(16'h1000); emit(16'h1241); emit(16'h0C00); emit(16'h0A01); emit(16'h0C00); halt();
        start_run(40);
        chk("R11 output count", 16'(out_cnt), 16'd2);
        chk("R11 first char", {8'h00, out_log[0]}, 16'h0041);
        chk("R11 second char", {8'h00, out_log[1]}, 16'h0042);

        // R12 input stall and zero extension
        new_prog();
        mem[DST] = 16'h5555;
        emit(16'h1300); emit(DST); emit(16'h1000); emit(16'hFFFF);
        emit(16'h0D00); emit(16'h5300); halt();
        start_run(30);
        chk("R12 in_ready while stalled", {15'd0, in_ready}, 16'h0001);
        chk("R12 no progress while stalled", mem[DST], 16'h5555);
        in_data  = 8'hC5;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R12 in_ready drops after take", {15'd0, in_ready}, 16'h0000);
        repeat (20) @(negedge clk);
        chk("R12 zero-extended input", mem[DST], 16'h00C5);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

endmodule